// File: doc/BRIEF.md
# Trace Buffer Pointer Access Controller

This block keeps the write pointer of a hardware trace buffer and decides, for every system-register read or write aimed at that pointer, what the access turns into. The decision comes from the requester's exception level (0 to 3), which higher levels exist, a set of trap-control bits, a two-bit buffer-ownership field and a three-bit nested-virtualisation mode. Each request yields one outcome: undefined instruction, trap to level 2, trap to level 3, redirect to a fixed memory offset, or direct access. Outcome, redirect offset and exception class are combinational. Pointer updates take effect on the clock edge.

The buffer writer advances the pointer by one entry on each advance strobe. A management-interrupt event freezes the pointer. From then on advance strobes are ignored until software writes the register directly. The lowest `ALIGN_BITS` bits of the pointer are tied to zero: they always read as 0, and writes to them are dropped.

Top module: `tbp_ctrl`

## Requirements
- R1: When `feat_present` is 0, or `req_el` is 0, the outcome is 1 (undefined). Outcome codes: 0 direct, 1 undefined, 2 trap to level 2, 3 trap to level 3, 4 redirect.
- R2: At level 1, if `el3_present`, `el3_nspb_trap` and `el3_undef_prio` are all 1, the outcome is 1, ahead of every other check.
- R3: At level 1, with R2 not matching, the outcome is 2 when all of these hold: `el2_enabled` is 1, `fgt_impl` is 1, fine-grain traps are allowed (`el3_present` is 0 or `el3_fgt_en` is 1), and the trap bit for the access direction is 1. Reads use `fgt_rd_trap` and writes use `fgt_wr_trap`.
- R4: At level 1, with R2 and R3 not matching, the outcome is 2 when `el2_enabled` is 1 and `own_field[0]` is 0, whatever `own_field[1]` holds.
- R5: At level 1 (after R2 to R4) and at level 2 (after the R2-style check), the level-3 trap condition (`el3_present` and `el3_nspb_trap`) gives outcome 1 when `el3_undef_sel` is 1 and outcome 3 otherwise.
- R6: At level 1, with no earlier check matching, `nv_mode` bits 2 and 0 both at 1 give outcome 4, with `redir_offset` = 0x810. In every other case `redir_offset` is 0.
- R7: At level 3 the outcome is always 0. At levels 1 and 2 the outcome is 0 when no check matches.
- R8: `exc_class` is 0x18 whenever the outcome is 2 or 3, and 0 otherwise.
- R9: A valid direct write loads `wdata` into the pointer at the next edge, with the low `ALIGN_BITS` bits forced to 0. A valid direct read returns the pointer on `rdata`; otherwise `rdata` is 0. A write with any other outcome leaves the pointer unchanged.
- R10: An advance strobe adds `ENTRY_BYTES` to the pointer when the pointer is not frozen and no interrupt or direct write occurs in the same cycle. A direct write in the same cycle wins over the strobe.
- R11: `mgmt_irq` sets `frozen`. While frozen, or in the cycle the interrupt arrives, advance strobes are ignored. A direct write clears `frozen` unless `mgmt_irq` is 1 in the same cycle.
- R12: After reset the pointer is 0 and `frozen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A register access is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Exception level of the requester |
| feat_present | input | 1 | Trace buffer feature implemented |
| el2_enabled | input | 1 | Level 2 is enabled |
| el3_present | input | 1 | Level 3 exists |
| el3_undef_prio | input | 1 | Level-3 undefined-priority condition |
| el3_nspb_trap | input | 1 | Level-3 buffer trap condition |
| el3_undef_sel | input | 1 | Level-3 trap becomes undefined instead |
| fgt_impl | input | 1 | Fine-grain traps implemented |
| el3_fgt_en | input | 1 | Level-3 enable for fine-grain traps |
| fgt_rd_trap | input | 1 | Fine-grain trap bit for reads |
| fgt_wr_trap | input | 1 | Fine-grain trap bit for writes |
| own_field | input | 2 | Buffer-ownership field |
| nv_mode | input | 3 | Nested-virtualisation mode |
| wdata | input | 64 | Write data |
| mgmt_irq | input | 1 | Management-interrupt event |
| adv_strobe | input | 1 | Advance strobe from the buffer writer |
| outcome | output | 3 | Outcome code |
| redir_offset | output | 12 | Memory offset for a redirect |
| exc_class | output | 6 | Exception class for a trap |
| rdata | output | 64 | Read data for a direct read |
| ptr | output | 64 | Current pointer value |
| frozen | output | 1 | Pointer frozen |

## Verification
Directed cases set up one input pattern per step of the priority chain. Each pattern sets the bits of that step together with the bits of every lower step, so a check that was skipped or evaluated out of order produces a wrong outcome code. Read/write pairs with only one fine-grain trap bit set show whether the bit is chosen by access direction. Own-field and mode values that differ only in a don't-care bit show whether that bit is ignored. For the pointer, the cases are: advance strobes alone, a strobe in the same cycle as a write, a strobe during and after a freeze, and writes with unaligned data. Together they separate the write-wins ordering, freeze release and low-bit masking. A long random run with a behavioural model then checks every output against the model on every cycle.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic [2:0] {
        OUT_DIRECT = 3'd0,
        OUT_UNDEF  = 3'd1,
        OUT_TRAP2  = 3'd2,
        OUT_TRAP3  = 3'd3,
        OUT_REDIR  = 3'd4
    } outcome_e;

    typedef struct packed {
        logic       write;
        logic [1:0] el;
        logic       feat;
        logic       el2_en;
        logic       el3_here;
        logic       undef_prio;
        logic       nspb_trap;
        logic       undef_sel;
        logic       fgt_impl;
        logic       fgt_en;
        logic       fgt_rd;
        logic       fgt_wr;
        logic [1:0] own;
        logic [2:0] nv;
    } req_ctx_t;

    typedef struct packed {
        outcome_e    code;
        logic [11:0] offset;
        logic [5:0]  ec;
    } verdict_t;

endpackage

// File: rtl/tbp_access_decode.sv
module tbp_access_decode
    import tbp_pkg::*;
#(
    parameter logic [11:0] REDIR_OFF = 12'h810,
    parameter logic [5:0]  TRAP_EC   = 6'h18
) (
    input  req_ctx_t ctx,
    output verdict_t verdict
);

    logic trap3_hit;
    logic fgt_allowed;
    logic fgt_bit;
    logic nv_redirect;
    logic unused_dontcare;

    always_comb begin
        trap3_hit   = ctx.el3_here & ctx.nspb_trap;
        fgt_allowed = ~ctx.el3_here | ctx.fgt_en;
        fgt_bit     = ctx.write ? ctx.fgt_wr : ctx.fgt_rd;
        nv_redirect = ctx.nv[2] & ctx.nv[0];
    end

    assign unused_dontcare = ctx.own[1] ^ ctx.nv[1];

    // Level-1 chain, in the order the checks are resolved
    function automatic outcome_e resolve_el1();
        outcome_e r;
        if (trap3_hit && ctx.undef_prio)                       r = OUT_UNDEF;
        else if (ctx.el2_en && ctx.fgt_impl && fgt_allowed && fgt_bit)
                                                                r = OUT_TRAP2;
        else if (ctx.el2_en && !ctx.own[0])                    r = OUT_TRAP2;
        else if (trap3_hit)                                     r = ctx.undef_sel ? OUT_UNDEF : OUT_TRAP3;
        else if (nv_redirect)                                   r = OUT_REDIR;
        else                                                    r = OUT_DIRECT;
        return r;
    endfunction

    // Level-2 chain: only the level-3 checks apply
    function automatic outcome_e resolve_el2();
        outcome_e r;
        if (trap3_hit && ctx.undef_prio)  r = OUT_UNDEF;
        else if (trap3_hit)               r = ctx.undef_sel ? OUT_UNDEF : OUT_TRAP3;
        else                              r = OUT_DIRECT;
        return r;
    endfunction

    outcome_e code_c;

    always_comb begin
        if (!ctx.feat) begin
            code_c = OUT_UNDEF;
        end else begin
            unique case (ctx.el)
                2'd0:    code_c = OUT_UNDEF;
                2'd1:    code_c = resolve_el1();
                2'd2:    code_c = resolve_el2();
                default: code_c = OUT_DIRECT;
            endcase
        end
    end

    always_comb begin
        verdict.code   = code_c;
        verdict.offset = (code_c == OUT_REDIR) ? REDIR_OFF : 12'd0;
        verdict.ec     = (code_c == OUT_TRAP2 || code_c == OUT_TRAP3) ? TRAP_EC : 6'd0;
    end

endmodule

// File: rtl/tbp_ptr_reg.sv
module tbp_ptr_reg #(
    parameter int PTR_W       = 64,
    parameter int ALIGN_BITS  = 4,
    parameter int ENTRY_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             adv,
    input  logic             irq,
    output logic [PTR_W-1:0] ptr_o,
    output logic             frozen_o
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(ENTRY_BYTES);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             frozen;
    } state_t;

    state_t st_d, st_q;
    logic [PTR_W-1:0] wr_aligned;
    logic [PTR_W-1:0] ptr_aligned;

    // Low bits are hard zero; a zero-width mask needs no logic at all
    generate
        if (ALIGN_BITS > 0) begin : g_mask
            assign wr_aligned  = {wr_data[PTR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            assign ptr_aligned = {st_q.ptr[PTR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end else begin : g_nomask
            assign wr_aligned  = wr_data;
            assign ptr_aligned = st_q.ptr;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ptr = wr_aligned;
        end else if (adv && !st_q.frozen && !irq) begin
            st_d.ptr = ptr_aligned + STEP;
        end
        if (irq) begin
            st_d.frozen = 1'b1;
        end else if (wr_en) begin
            st_d.frozen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o    = ptr_aligned;
    assign frozen_o = st_q.frozen;

endmodule

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
    import tbp_pkg::*;
#(
    parameter int          PTR_W       = 64,
    parameter int          BUF_ALIGN   = 8,
    parameter int          ALIGN_BITS  = 4,
    parameter int          ENTRY_BYTES = 64,
    parameter logic [11:0] REDIR_OFF   = 12'h810,
    parameter logic [5:0]  TRAP_EC     = 6'h18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_el,
    input  logic             feat_present,
    input  logic             el2_enabled,
    input  logic             el3_present,
    input  logic             el3_undef_prio,
    input  logic             el3_nspb_trap,
    input  logic             el3_undef_sel,
    input  logic             fgt_impl,
    input  logic             el3_fgt_en,
    input  logic             fgt_rd_trap,
    input  logic             fgt_wr_trap,
    input  logic [1:0]       own_field,
    input  logic [2:0]       nv_mode,
    input  logic [PTR_W-1:0] wdata,
    input  logic             mgmt_irq,
    input  logic             adv_strobe,
    output logic [2:0]       outcome,
    output logic [11:0]      redir_offset,
    output logic [5:0]       exc_class,
    output logic [PTR_W-1:0] rdata,
    output logic             frozen,
    output logic [PTR_W-1:0] ptr
);

    // Tie-off width clamped to the buffer alignment limit
    localparam int LOW_ZERO = (ALIGN_BITS > BUF_ALIGN) ? BUF_ALIGN : ALIGN_BITS;

    req_ctx_t ctx;
    verdict_t verdict;
    logic     direct_hit;
    logic     wr_en;

    always_comb begin
        ctx.write      = req_write;
        ctx.el         = req_el;
        ctx.feat       = feat_present;
        ctx.el2_en     = el2_enabled;
        ctx.el3_here   = el3_present;
        ctx.undef_prio = el3_undef_prio;
        ctx.nspb_trap  = el3_nspb_trap;
        ctx.undef_sel  = el3_undef_sel;
        ctx.fgt_impl   = fgt_impl;
        ctx.fgt_en     = el3_fgt_en;
        ctx.fgt_rd     = fgt_rd_trap;
        ctx.fgt_wr     = fgt_wr_trap;
        ctx.own        = own_field;
        ctx.nv         = nv_mode;
    end

    tbp_access_decode #(
        .REDIR_OFF (REDIR_OFF),
        .TRAP_EC   (TRAP_EC)
    ) u_decode (
        .ctx     (ctx),
        .verdict (verdict)
    );

    assign direct_hit = req_valid && (verdict.code == OUT_DIRECT);
    assign wr_en      = direct_hit && req_write;

    tbp_ptr_reg #(
        .PTR_W       (PTR_W),
        .ALIGN_BITS  (LOW_ZERO),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wdata),
        .adv      (adv_strobe),
        .irq      (mgmt_irq),
        .ptr_o    (ptr),
        .frozen_o (frozen)
    );

    assign outcome      = verdict.code;
    assign redir_offset = verdict.offset;
    assign exc_class    = verdict.ec;
    assign rdata        = (direct_hit && !req_write) ? ptr : '0;

endmodule

// File: rtl/tbp_ctrl_chk.sv
module tbp_ctrl_chk #(
    parameter int PTR_W       = 64,
    parameter int ALIGN_BITS  = 4,
    parameter int ENTRY_BYTES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_el,
    input logic             feat_present,
    input logic             mgmt_irq,
    input logic             adv_strobe,
    input logic [2:0]       outcome,
    input logic [11:0]      redir_offset,
    input logic [5:0]       exc_class,
    input logic             frozen,
    input logic [PTR_W-1:0] ptr
);

    logic wr_direct;
    assign wr_direct = req_valid && req_write && (outcome == 3'd0);

    AST_LOW_EL_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_el == 2'd0 || !feat_present) |-> outcome == 3'd1); // R1

    AST_TOP_LEVEL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_present && req_el == 2'd3) |-> outcome == 3'd0); // R7

    AST_REDIR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome == 3'd4) |-> redir_offset == 12'h810); // R6

    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome == 3'd2 || outcome == 3'd3) |-> exc_class == 6'h18); // R8

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ptr[ALIGN_BITS-1:0] == '0); // R9

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !wr_direct) |=> ptr == $past(ptr)); // R11

    AST_IRQ_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_irq |=> frozen); // R11

    AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_strobe && !frozen && !mgmt_irq && !wr_direct)
        |=> ptr == $past(ptr) + PTR_W'(ENTRY_BYTES)); // R10

endmodule

bind tbp_ctrl tbp_ctrl_chk #(
    .PTR_W       (PTR_W),
    .ALIGN_BITS  (LOW_ZERO),
    .ENTRY_BYTES (ENTRY_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_el       (req_el),
    .feat_present (feat_present),
    .mgmt_irq     (mgmt_irq),
    .adv_strobe   (adv_strobe),
    .outcome      (outcome),
    .redir_offset (redir_offset),
    .exc_class    (exc_class),
    .frozen       (frozen),
    .ptr          (ptr)
);

// File: tb/tbp_ctrl_tb.sv
`timescale 1ns/1ps
module tbp_ctrl_tb;

    localparam int  ALIGN   = 4;
    localparam int  ENTRY   = 64;
    localparam real HALF    = 10.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_el = 0;
    logic feat_present = 0, el2_enabled = 0, el3_present = 0, el3_undef_prio = 0;
    logic el3_nspb_trap = 0, el3_undef_sel = 0, fgt_impl = 0, el3_fgt_en = 0;
    logic fgt_rd_trap = 0, fgt_wr_trap = 0;
    logic [1:0] own_field = 0;
    logic [2:0] nv_mode = 0;
    logic [63:0] wdata = 0;
    logic mgmt_irq = 0, adv_strobe = 0;
    logic [2:0] outcome;
    logic [11:0] redir_offset;
    logic [5:0] exc_class;
    logic [63:0] rdata, ptr;
    logic frozen;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [63:0] m_ptr = 0;
    bit          m_frozen = 0;
    string       m_tag;

    always #(HALF) clk = ~clk;

    tbp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_el(req_el), .feat_present(feat_present), .el2_enabled(el2_enabled),
        .el3_present(el3_present), .el3_undef_prio(el3_undef_prio),
        .el3_nspb_trap(el3_nspb_trap), .el3_undef_sel(el3_undef_sel),
        .fgt_impl(fgt_impl), .el3_fgt_en(el3_fgt_en), .fgt_rd_trap(fgt_rd_trap),
        .fgt_wr_trap(fgt_wr_trap), .own_field(own_field), .nv_mode(nv_mode),
        .wdata(wdata), .mgmt_irq(mgmt_irq), .adv_strobe(adv_strobe),
        .outcome(outcome), .redir_offset(redir_offset), .exc_class(exc_class),
        .rdata(rdata), .frozen(frozen), .ptr(ptr)
    );

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected outcome worked out directly from the requirement text
    function automatic int expect_code(output string tag);
        bit t3 = el3_present && el3_nspb_trap;
        bit fg = req_write ? fgt_wr_trap : fgt_rd_trap;
        if (!feat_present || req_el == 0) begin tag = "R1"; return 1; end
        if (req_el == 3) begin tag = "R7"; return 0; end
        if (t3 && el3_undef_prio) begin tag = "R2"; return 1; end
        if (req_el == 1) begin
            if (el2_enabled && fgt_impl && (!el3_present || el3_fgt_en) && fg) begin
                tag = "R3"; return 2;
            end
            if (el2_enabled && own_field[0] == 1'b0) begin tag = "R4"; return 2; end
        end
        if (t3) begin tag = "R5"; return el3_undef_sel ? 1 : 3; end
        if (req_el == 1 && nv_mode[2] && nv_mode[0]) begin tag = "R6"; return 4; end
        tag = "R7";
        return 0;
    endfunction

    // One cycle: inputs already driven; compare, then advance model over the edge
    task automatic cycle();
        int code;
        bit wr;
        #1;
        code = expect_code(m_tag);
        check(m_tag, "outcome", 64'(outcome), 64'(code));
        check("R6", "redir_offset", 64'(redir_offset), (code == 4) ? 64'h810 : 64'h0);
        check("R8", "exc_class", 64'(exc_class), (code == 2 || code == 3) ? 64'h18 : 64'h0);
        check("R9", "rdata", rdata, (req_valid && !req_write && code == 0) ? m_ptr : 64'h0);
        check(m_frozen ? "R11" : "R10", "ptr", ptr, m_ptr);
        check("R11", "frozen", 64'(frozen), 64'(m_frozen));
        wr = req_valid && req_write && code == 0;
        @(posedge clk);
        if (wr) m_ptr = wdata & ~64'(15);
        else if (adv_strobe && !m_frozen && !mgmt_irq) m_ptr = m_ptr + 64'(ENTRY);
        if (mgmt_irq) m_frozen = 1;
        else if (wr) m_frozen = 0;
        @(negedge clk);
    endtask

    task automatic idle_ctl();
        req_valid = 0; req_write = 0; req_el = 2'd1; feat_present = 1;
        el2_enabled = 0; el3_present = 0; el3_undef_prio = 0; el3_nspb_trap = 0;
        el3_undef_sel = 0; fgt_impl = 0; el3_fgt_en = 0; fgt_rd_trap = 0;
        fgt_wr_trap = 0; own_field = 2'b01; nv_mode = 0; mgmt_irq = 0; adv_strobe = 0;
    endtask

    task automatic direct_write(logic [63:0] d);
        idle_ctl(); req_valid = 1; req_write = 1; req_el = 2'd3; wdata = d;
        cycle();
    endtask

    initial begin
        #(2.0 * HALF * 200000.0);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_ctl();
        repeat (3) @(negedge clk);
        check("R12", "reset ptr", ptr, 64'h0);
        check("R12", "reset frozen", 64'(frozen), 64'h0);
        rst_n = 1;
        @(negedge clk);

        // R1: feature absent / level 0
        idle_ctl(); req_valid = 1; feat_present = 0; req_el = 3; cycle();
        idle_ctl(); req_valid = 1; req_el = 0; cycle();
        // R2: undefined-priority beats everything below it
        idle_ctl(); req_valid = 1; el3_present = 1; el3_nspb_trap = 1; el3_undef_prio = 1;
        el2_enabled = 1; fgt_impl = 1; el3_fgt_en = 1; fgt_rd_trap = 1; own_field = 0; nv_mode = 3'b101;
        cycle();
        // R3: direction-selected fine-grain bits
        idle_ctl(); req_valid = 1; el2_enabled = 1; fgt_impl = 1; fgt_wr_trap = 1; cycle();
        req_write = 1; wdata = 64'hFFFF; cycle();
        check("R9", "non-direct write keeps ptr", ptr, 64'h0);
        el3_present = 1; el3_fgt_en = 0; cycle();
        // R4: own field x0 with don't-care bit 1
        idle_ctl(); req_valid = 1; el2_enabled = 1; own_field = 2'b10; el3_present = 1;
        el3_nspb_trap = 1; cycle();
        // R5: level-3 trap at both levels, both selections
        idle_ctl(); req_valid = 1; el3_present = 1; el3_nspb_trap = 1; nv_mode = 3'b111; cycle();
        el3_undef_sel = 1; cycle();
        req_el = 2; el3_undef_sel = 0; cycle();
        // R6: redirect, and the level-2 case where it does not apply
        idle_ctl(); req_valid = 1; nv_mode = 3'b111; cycle();
        nv_mode = 3'b110; cycle();
        req_el = 2; nv_mode = 3'b101; cycle();
        // R9/R10: write, read, advance, write wins
        direct_write(64'h1234_5678_9ABC_DEFF);
        check("R9", "aligned write", ptr, 64'h1234_5678_9ABC_DEF0);
        idle_ctl(); req_valid = 1; req_el = 3; cycle();
        idle_ctl(); adv_strobe = 1; cycle(); cycle();
        idle_ctl(); adv_strobe = 1; req_valid = 1; req_write = 1; req_el = 3; wdata = 64'h100; cycle();
        check("R10", "write wins", ptr, 64'h100);
        // R11: freeze, ignored strobes, release by write
        idle_ctl(); mgmt_irq = 1; adv_strobe = 1; cycle();
        idle_ctl(); adv_strobe = 1; cycle(); cycle();
        check("R11", "frozen ptr", ptr, 64'h100);
        direct_write(64'h200);
        idle_ctl(); adv_strobe = 1; cycle();
        check("R11", "released ptr", ptr, 64'h240);

        // random run against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            req_valid = r[0]; req_write = r[1]; req_el = r[3:2];
            feat_present = (r[7:4] != 0); el2_enabled = r[8]; el3_present = r[9];
            el3_undef_prio = r[10]; el3_nspb_trap = r[11]; el3_undef_sel = r[12];
            fgt_impl = r[13]; el3_fgt_en = r[14]; fgt_rd_trap = r[15]; fgt_wr_trap = r[16];
            own_field = r[18:17]; nv_mode = r[21:19];
            mgmt_irq = (r[25:22] == 0); adv_strobe = r[26];
            wdata = {$urandom, $urandom};
            cycle();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule